// File: doc/BRIEF.md
# Push-Pull PWM Controller with Dead-Time

This block produces fixed-frequency pulse-width-modulated drive for a switching power stage. A free-running counter forms a linear rising ramp of `2^RAMP_W` counts. A drive pulse is active only while the ramp is above two limits. The first limit is the dead-time word plus a fixed built-in offset of about one twenty-fifth of the period. The second is the larger of two error words. A larger control value therefore gives a pulse that is shorter by the same number of counts.

A steering flip-flop advances at every ramp wrap. In push-pull mode it sends successive pulses to drive A and drive B in turn, so each drive runs at half the ramp rate. In single-ended mode the flip-flop is held, and both drives pulse together on every ramp cycle so that they can be paralleled. The control words and the mode are captured once per ramp cycle, at the wrap. A pulse therefore never changes width while it is being delivered. A strobe output marks the count at which the ramp sits at zero.

Top module: `pwm_pp_ctrl`

## Requirements
- R1: While and after synchronous reset the ramp is at zero, both drives are low and the wrap strobe is high. The captured limits are at their maximum, so the first ramp cycle after reset gives no pulse. The first pulse in push-pull mode appears on drive A.
- R2: The ramp steps by one every clock from 0 to `2^RAMP_W-1` and then wraps. `ramp_wrap` is high exactly in the cycles where the ramp is 0, and both drives are low in those cycles.
- R3: Within a ramp cycle, a drive is high exactly while the ramp value is strictly greater than the captured threshold. The threshold is the maximum of (dead-time word + `DT_OFFSET`), error word A and error word B. The pulse width is `2^RAMP_W-1-threshold` cycles, and a pulse that has begun stays high until the wrap.
- R4: Of the two error words, the larger sets the width; the smaller has no effect.
- R5: With all control words at zero, both drives stay low for ramp values 0 to `DT_OFFSET`. With the defaults this gives 245 of 256 cycles. Raising the dead-time word shortens the pulse by the same count.
- R6: Control words and mode are captured at the clock edge where the ramp leaves its last count. Changes on these inputs during a ramp cycle do not alter that cycle's pulses.
- R7: In push-pull mode (`mode_single` = 0) the drives are never high together. Successive ramp cycles route their pulse to A, B, A, B and so on, and the steering advances on every wrap even when the width is zero.
- R8: In single-ended mode (`mode_single` = 1) both drives are identical on every cycle and pulse on every ramp cycle.
- R9: The ramp cycle that follows a single-ended cycle in push-pull mode routes its pulse to drive A.
- R10: A threshold of `2^RAMP_W-1` or above gives zero duty cycle on both drives for that ramp cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_single | input | 1 | 1 = both drives together, 0 = alternate drives |
| dead_word | input | RAMP_W | Extra dead-time limit, unsigned |
| err_a_word | input | RAMP_W | Error word A, unsigned |
| err_b_word | input | RAMP_W | Error word B, unsigned |
| drv_a | output | 1 | Drive A |
| drv_b | output | 1 | Drive B |
| ramp_wrap | output | 1 | High while the ramp is at zero |

## Verification
The capture of new control words and the toggle of the steering flip-flop happen at the same clock edge: the edge where the ramp wraps. The bench provokes this coincidence by changing the width and the mode together at the last ramp count. It also changes them again in the middle of a cycle. A behavioural per-cycle model then judges both effects together. It checks that the width belongs to the new cycle and the output choice follows the alternation. Per-cycle pulse counts per output confirm both the width and the routing.

// File: rtl/pwm_pp_pkg.sv
package pwm_pp_pkg;
   typedef enum logic {
      STEER_A = 1'b0,
      STEER_B = 1'b1
   } steer_e;

   typedef enum logic {
      MODE_ALTERNATE = 1'b0,
      MODE_PARALLEL  = 1'b1
   } drive_mode_e;
endpackage

// File: rtl/pwm_pp_ramp.sv
module pwm_pp_ramp #(
   parameter int RAMP_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   output logic [RAMP_W-1:0] ramp_o,
   output logic              last_o,
   output logic              zero_o
);
   localparam logic [RAMP_W-1:0] RAMP_TOP = '1;

   logic [RAMP_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign ramp_o = cnt_q;
   assign last_o = (cnt_q == RAMP_TOP);
   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_pp_thresh.sv
module pwm_pp_thresh
   import pwm_pp_pkg::*;
#(
   parameter int RAMP_W    = 8,
   parameter int DT_OFFSET = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              mode_i,
   input  logic [RAMP_W-1:0] dead_i,
   input  logic [RAMP_W-1:0] err_a_i,
   input  logic [RAMP_W-1:0] err_b_i,
   output logic [RAMP_W:0]   thr_o,
   output drive_mode_e       mode_o
);
   localparam int TW = RAMP_W + 1;
   localparam logic [TW-1:0] OFF_V = TW'(DT_OFFSET);

   logic [TW-1:0]     dt_sum;
   logic [RAMP_W-1:0] err_max;
   logic [TW-1:0]     thr_d;
   logic [TW-1:0]     thr_q;
   drive_mode_e       mode_q;

   always_comb begin
      dt_sum  = {1'b0, dead_i} + OFF_V;
      err_max = (err_a_i > err_b_i) ? err_a_i : err_b_i;
      thr_d   = (dt_sum > {1'b0, err_max}) ? dt_sum : {1'b0, err_max};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         thr_q  <= '1;
         mode_q <= MODE_ALTERNATE;
      end else if (load_i) begin
         thr_q  <= thr_d;
         mode_q <= drive_mode_e'(mode_i);
      end
   end

   assign thr_o  = thr_q;
   assign mode_o = mode_q;
endmodule

// File: rtl/pwm_pp_steer.sv
module pwm_pp_steer
   import pwm_pp_pkg::*;
#(
   parameter int RAMP_W         = 8,
   parameter bit OUT_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  drive_mode_e       mode_i,
   input  logic              zero_i,
   input  logic [RAMP_W-1:0] ramp_i,
   input  logic [RAMP_W:0]   thr_i,
   output logic              drv_a_o,
   output logic              drv_b_o
);
   steer_e sel_q;
   logic   armed_q;
   logic   pulse_on;
   logic   en_a;
   logic   en_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q   <= STEER_A;
         armed_q <= 1'b0;
      end else if (adv_i) begin
         armed_q <= 1'b1;
         if (mode_i == MODE_PARALLEL) sel_q <= STEER_A;
         else if (armed_q)            sel_q <= (sel_q == STEER_A) ? STEER_B : STEER_A;
      end
   end

   always_comb begin
      pulse_on = ({1'b0, ramp_i} > thr_i) && !zero_i;
      en_a     = pulse_on && ((mode_i == MODE_PARALLEL) || (sel_q == STEER_A));
      en_b     = pulse_on && ((mode_i == MODE_PARALLEL) || (sel_q == STEER_B));
   end

   generate
      if (OUT_ACTIVE_LOW) begin : g_pol_low
         assign drv_a_o = ~en_a;
         assign drv_b_o = ~en_b;
      end else begin : g_pol_high
         assign drv_a_o = en_a;
         assign drv_b_o = en_b;
      end
   endgenerate
endmodule

// File: rtl/pwm_pp_ctrl.sv
module pwm_pp_ctrl
   import pwm_pp_pkg::*;
#(
   parameter int RAMP_W         = 8,
   parameter int DT_OFFSET      = (1 << RAMP_W) / 25,
   parameter bit OUT_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_single,
   input  logic [RAMP_W-1:0] dead_word,
   input  logic [RAMP_W-1:0] err_a_word,
   input  logic [RAMP_W-1:0] err_b_word,
   output logic              drv_a,
   output logic              drv_b,
   output logic              ramp_wrap
);
   localparam int PERIOD = 1 << RAMP_W;

   generate
      if (RAMP_W < 3 || RAMP_W > 16) begin : g_bad_width
         $error("pwm_pp_ctrl: RAMP_W must lie in 3..16");
      end
      if (DT_OFFSET < 1 || DT_OFFSET >= PERIOD - 1) begin : g_bad_offset
         $error("pwm_pp_ctrl: DT_OFFSET must lie in 1..PERIOD-2");
      end
   endgenerate

   logic [RAMP_W-1:0] ramp_q;
   logic              ramp_last;
   logic              ramp_zero;
   logic [RAMP_W:0]   thr_q;
   drive_mode_e       mode_q;

   pwm_pp_ramp #(.RAMP_W(RAMP_W)) u_ramp (
      .clk    (clk),
      .rst    (rst),
      .ramp_o (ramp_q),
      .last_o (ramp_last),
      .zero_o (ramp_zero)
   );

   pwm_pp_thresh #(.RAMP_W(RAMP_W), .DT_OFFSET(DT_OFFSET)) u_thresh (
      .clk     (clk),
      .rst     (rst),
      .load_i  (ramp_last),
      .mode_i  (mode_single),
      .dead_i  (dead_word),
      .err_a_i (err_a_word),
      .err_b_i (err_b_word),
      .thr_o   (thr_q),
      .mode_o  (mode_q)
   );

   pwm_pp_steer #(.RAMP_W(RAMP_W), .OUT_ACTIVE_LOW(OUT_ACTIVE_LOW)) u_steer (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (ramp_last),
      .mode_i  (mode_q),
      .zero_i  (ramp_zero),
      .ramp_i  (ramp_q),
      .thr_i   (thr_q),
      .drv_a_o (drv_a),
      .drv_b_o (drv_b)
   );

   assign ramp_wrap = ramp_zero;
endmodule

// File: rtl/pwm_pp_chk.sv
module pwm_pp_chk #(
   parameter int RAMP_W         = 8,
   parameter int DT_OFFSET      = 10,
   parameter bit OUT_ACTIVE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              drv_a,
   input logic              drv_b,
   input logic              ramp_wrap,
   input logic [RAMP_W-1:0] ramp_q,
   input logic [RAMP_W:0]   thr_q,
   input logic              mode_q
);
   logic a_on;
   logic b_on;
   assign a_on = drv_a ^ OUT_ACTIVE_LOW;
   assign b_on = drv_b ^ OUT_ACTIVE_LOW;

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!a_on && !b_on && ramp_wrap)); // R1
   AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst) ramp_wrap |=> !ramp_wrap); // R2
   AST_WRAP_DARK: assert property (@(posedge clk) disable iff (rst) ramp_wrap |-> (!a_on && !b_on)); // R2
   AST_PULSE_HOLDS_A: assert property (@(posedge clk) disable iff (rst) a_on |=> (a_on || ramp_wrap)); // R3
   AST_PULSE_HOLDS_B: assert property (@(posedge clk) disable iff (rst) b_on |=> (b_on || ramp_wrap)); // R3
   AST_DEADBAND: assert property (@(posedge clk) disable iff (rst) (int'(ramp_q) <= DT_OFFSET) |-> (!a_on && !b_on)); // R5
   AST_LIMIT_STEADY: assert property (@(posedge clk) disable iff (rst) !ramp_wrap |-> ($stable(thr_q) && $stable(mode_q))); // R6
   AST_PP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !mode_q |-> !(a_on && b_on)); // R7
   AST_SE_TOGETHER: assert property (@(posedge clk) disable iff (rst) mode_q |-> (a_on == b_on)); // R8
endmodule

bind pwm_pp_ctrl pwm_pp_chk #(
   .RAMP_W(RAMP_W),
   .DT_OFFSET(DT_OFFSET),
   .OUT_ACTIVE_LOW(OUT_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .drv_a     (drv_a),
   .drv_b     (drv_b),
   .ramp_wrap (ramp_wrap),
   .ramp_q    (ramp_q),
   .thr_q     (thr_q),
   .mode_q    (mode_q)
);

// File: tb/pwm_pp_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_pp_ctrl_bench;
   localparam int RAMP_W = 8;
   localparam int PERIOD = 1 << RAMP_W;
   localparam int DT_OFF = PERIOD / 25;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_single = 1'b0;
   logic [RAMP_W-1:0] dead_word = '0;
   logic [RAMP_W-1:0] err_a_word = '0;
   logic [RAMP_W-1:0] err_b_word = '0;
   logic drv_a, drv_b, ramp_wrap;

   int n_cmp = 0;
   int n_bad = 0;
   bit model_live = 0;

   // behavioural reference state
   int m_cnt, m_thr, m_mode, m_sel, m_armed;

   always #4 clk = ~clk;

   pwm_pp_ctrl #(.RAMP_W(RAMP_W)) u_pwm_pp_ctrl (
      .clk(clk), .rst(rst), .mode_single(mode_single),
      .dead_word(dead_word), .err_a_word(err_a_word), .err_b_word(err_b_word),
      .drv_a(drv_a), .drv_b(drv_b), .ramp_wrap(ramp_wrap)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int thr_of(input int dd, input int ea, input int eb);
      int t;
      t = dd + DT_OFF;
      if (ea > t) t = ea;
      if (eb > t) t = eb;
      return t;
   endfunction

   function automatic int width_of(input int t);
      return (t >= PERIOD - 1) ? 0 : PERIOD - 1 - t;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_thr = 2 * PERIOD; m_mode = 0; m_sel = 0; m_armed = 0;
         model_live = 1;
      end else if (m_cnt == PERIOD - 1) begin
         if (m_mode != 0)     m_sel = 0;
         else if (m_armed != 0) m_sel = 1 - m_sel;
         m_armed = 1;
         m_thr  = thr_of(int'(dead_word), int'(err_a_word), int'(err_b_word));
         m_mode = int'(mode_single);
         m_cnt  = 0;
      end else begin
         m_cnt = m_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (model_live && !rst) begin
         int on, ea, eb;
         on = (m_cnt > m_thr && m_cnt != 0) ? 1 : 0;
         ea = (on != 0 && (m_mode != 0 || m_sel == 0)) ? 1 : 0;
         eb = (on != 0 && (m_mode != 0 || m_sel == 1)) ? 1 : 0;
         chk("R2 wrap strobe", int'(ramp_wrap), (m_cnt == 0) ? 1 : 0);
         chk("R3 R7 R8 drive A", int'(drv_a), ea);
         chk("R3 R7 R8 drive B", int'(drv_b), eb);
      end
   end

   // Called at the negedge of the last ramp count; applies inputs, then
   // counts drive-high cycles over the next whole ramp cycle.
   task automatic run_cycle(input int dd, input int ea, input int eb, input bit se,
                            input bit mid, input int exp_a, input int exp_b, input string req);
      int ca = 0;
      int cb = 0;
      dead_word = RAMP_W'(dd); err_a_word = RAMP_W'(ea); err_b_word = RAMP_W'(eb);
      mode_single = se;
      @(negedge clk);
      chk({req, " cycle start"}, int'(ramp_wrap), 1);
      for (int i = 0; i < PERIOD; i++) begin
         if (drv_a) ca++;
         if (drv_b) cb++;
         if (mid && i == PERIOD / 2) begin
            dead_word = '0; err_a_word = '0; err_b_word = '0; mode_single = ~mode_single;
         end
         if (i < PERIOD - 1) @(negedge clk);
      end
      chk({req, " width A"}, ca, exp_a);
      chk({req, " width B"}, cb, exp_b);
   endtask

   initial begin
      int w;
      int ca = 0;
      int cb = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset drive A", int'(drv_a), 0);
      chk("R1 reset drive B", int'(drv_b), 0);
      chk("R1 reset wrap", int'(ramp_wrap), 1);
      rst = 1'b0;
      // first ramp cycle after reset: maximal captured limits
      for (int i = 0; i < PERIOD; i++) begin
         if (drv_a) ca++;
         if (drv_b) cb++;
         if (i < PERIOD - 1) @(negedge clk);
      end
      chk("R1 R10 first cycle A", ca, 0);
      chk("R1 R10 first cycle B", cb, 0);

      w = width_of(thr_of(0, 0, 0));
      chk("R5 min dead-time width", w, PERIOD - 1 - DT_OFF);
      run_cycle(0, 0, 0, 0, 0, w, 0, "R1 R5 first pulse on A");
      run_cycle(0, 0, 0, 0, 0, 0, w, "R7 alternate to B");
      run_cycle(50, 0, 0, 0, 0, width_of(50 + DT_OFF), 0, "R5 added dead-time");
      run_cycle(0, 100, 20, 0, 0, 0, width_of(100), "R4 error A wins");
      run_cycle(0, 20, 200, 0, 0, width_of(200), 0, "R4 error B wins");
      run_cycle(0, PERIOD - 1, 0, 0, 0, 0, 0, "R10 error at ramp max");
      run_cycle(PERIOD - 1, 0, 0, 0, 0, 0, 0, "R10 dead-time beyond max");
      run_cycle(0, 80, 0, 1, 0, width_of(80), width_of(80), "R8 parallel drives");
      run_cycle(0, 128, 0, 1, 1, width_of(128), width_of(128), "R6 mid-cycle change ignored");
      run_cycle(0, 0, 0, 0, 0, w, 0, "R9 restart on A");
      run_cycle(0, 0, 0, 0, 0, 0, w, "R7 then B");

      // coincidence of capture and steering under changing inputs
      for (int k = 0; k < 30; k++) begin
         dead_word   = RAMP_W'($urandom_range(0, 60));
         err_a_word  = RAMP_W'($urandom_range(0, PERIOD - 1));
         err_b_word  = RAMP_W'($urandom_range(0, PERIOD - 1));
         mode_single = ($urandom_range(0, 3) == 0);
         repeat ($urandom_range(1, PERIOD / 2)) @(negedge clk);
      end
      repeat (PERIOD) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule